// File: doc/BRIEF.md
# Two-Operand Arithmetic and Logic Unit with Packed-Decimal Add

This unit performs one of twelve two-operand operations on a source value and a destination value, either at full 16-bit width or on the low byte only. It returns the result, a strobe saying whether the destination should be written, and a four-bit status vector. Operations that leave the status alone simply return the incoming status vector unchanged. Operand fetch and write-back sequencing are handled elsewhere. The unit only computes.

One operation is accepted per cycle when `in_valid` is high. Its outputs are registered and appear on the following cycle together with `out_valid`. The status vector is ordered V (bit 3), N (bit 2), Z (bit 1), C (bit 0). The incoming carry is bit 0 of `flags_in`. Operation codes on `op_sel`: 0 move, 1 add, 2 add-with-carry, 3 subtract, 4 subtract-with-carry, 5 compare, 6 decimal add, 7 bit test, 8 bit clear, 9 bit set, 10 exclusive-or, 11 and. Codes 12 to 15 are unassigned.

Top module: `alu16_core`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `dst_we`, `result` and `flags_out` are all zero after that edge.
- R2: Outputs for an operation presented with `in_valid` high appear on the next clock edge with `out_valid` high. A cycle with `in_valid` low yields `out_valid` and `dst_we` low on the next edge.
- R3: With `byte_op` high, only bits 7:0 of both operands are used, `result[15:8]` is zero, N is result bit 7, and Z and C are computed over 8 bits. With `byte_op` low, N is result bit 15 and Z and C are computed over 16 bits.
- R4: Code 1 gives dst+src, code 2 gives dst+src+C, code 3 gives dst+not(src)+1 and code 4 gives dst+not(src)+C. Each writes the destination. C is the carry out of the selected width. V is set when the two addends have equal sign bits and the result's sign differs from them.
- R5: Code 5 (compare) produces the same V, N, Z, C as code 3 and deasserts `dst_we`.
- R6: Code 6 adds src+dst+C one 4-bit digit at a time, starting from the least significant digit. A digit sum above 9 has 6 added to it (kept to 4 bits) and passes a carry on. The result is written, C is the carry out of the top digit at the selected width, and V is cleared.
- R7: Code 11 writes src AND dst. Code 7 computes the same value without writing it. Both clear V and set C to the inverse of Z.
- R8: Code 10 writes src XOR dst, sets C to the inverse of Z, and sets V only when both operands are negative at the selected width.
- R9: Code 0 writes src, code 8 writes not(src) AND dst, and code 9 writes src OR dst. All three return `flags_in` unchanged on `flags_out`.
- R10: Codes 12 to 15 deassert `dst_we`, return `flags_in` unchanged, and give a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code |
| src_val | input | 16 | Source operand |
| dst_val | input | 16 | Destination operand |
| byte_op | input | 1 | 1 = byte width, 0 = word width |
| flags_in | input | 4 | Current status {V,N,Z,C}; C is the incoming carry |
| out_valid | output | 1 | Registered outputs hold a new operation |
| result | output | 16 | Operation result |
| dst_we | output | 1 | Destination should be written |
| flags_out | output | 4 | Updated status {V,N,Z,C} |

## Verification
The assertions check these rules on every cycle:
- the one-cycle valid handshake;
- the clearing of the upper byte in byte mode;
- the missing write strobe for compare and bit test;
- status pass-through for move, bit clear and bit set;
- the logical-operation rule tying C to the inverse of Z;
- the choice of N bit by width.

Only the bench's scenarios can show the arithmetic itself is right. That covers carry and overflow at both widths, borrow-style subtraction with the incoming carry, and digit correction in decimal add, including carry rippling across every digit and garbage in the ignored upper byte.

// File: rtl/alu16_pkg.sv
// Shared definitions for the two-operand ALU.
// Assumes a 16-bit datapath split into two equal halves for byte mode.
package alu16_pkg;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        OP_MOVE = 4'd0,
        OP_ADD  = 4'd1,
        OP_ADDC = 4'd2,
        OP_SUB  = 4'd3,
        OP_SUBC = 4'd4,
        OP_CMP  = 4'd5,
        OP_DADD = 4'd6,
        OP_BTST = 4'd7,
        OP_BCLR = 4'd8,
        OP_BSET = 4'd9,
        OP_XOR  = 4'd10,
        OP_AND  = 4'd11
    } alu_op_e;

    typedef struct packed {
        logic v;
        logic n;
        logic z;
        logic c;
    } alu_flags_t;
endpackage

// File: rtl/alu16_addsub.sv
// Binary adder split into two halves so the carry and overflow can be
// taken at half width (byte mode) or full width.
// Assumes the caller has already complemented b for subtraction.
module alu16_addsub #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         half_mode,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int H  = W / 2;
    localparam int HW = W - H;

    logic [H:0]  lo_sum;
    logic [HW:0] hi_sum;
    logic        sa, sb, sr;

    // Two chained half-width adds, then pick the carry and sign bits at the active width.
    always_comb begin
        lo_sum = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, cin};
        hi_sum = {1'b0, a[W-1:H]} + {1'b0, b[W-1:H]} + {{HW{1'b0}}, lo_sum[H]};
        sum    = {hi_sum[HW-1:0], lo_sum[H-1:0]};
        cout   = half_mode ? lo_sum[H] : hi_sum[HW];
        sa     = half_mode ? a[H-1]   : a[W-1];
        sb     = half_mode ? b[H-1]   : b[W-1];
        sr     = half_mode ? sum[H-1] : sum[W-1];
        ovf    = (sa == sb) && (sr != sa);
    end
endmodule

// File: rtl/alu16_bcd.sv
// Packed-decimal adder: a ripple of per-digit adders, each correcting
// sums above nine. Assumes W is a multiple of 8 so byte mode is W/8 digits.
module alu16_bcd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         half_mode,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int DIGITS = W / 4;
    localparam int HALF_D = DIGITS / 2;

    logic [DIGITS:0] dcarry;

    assign dcarry[0] = cin;

    for (genvar gi = 0; gi < DIGITS; gi++) begin : g_digit
        logic [4:0] raw;
        logic [4:0] fixed;
        // One decimal digit: binary add, then add six and carry when above nine.
        always_comb begin
            raw   = {1'b0, a[4*gi +: 4]} + {1'b0, b[4*gi +: 4]} + {4'd0, dcarry[gi]};
            fixed = raw + 5'd6;
        end
        assign dcarry[gi+1]   = (raw > 5'd9);
        assign sum[4*gi +: 4] = dcarry[gi+1] ? fixed[3:0] : raw[3:0];
    end

    assign cout = half_mode ? dcarry[HALF_D] : dcarry[DIGITS];
endmodule

// File: rtl/alu16_nzgen.sv
// Sign and zero detection at the selected width.
// Assumes the upper half of res is already cleared in half mode.
module alu16_nzgen #(
    parameter int W = 16
) (
    input  logic [W-1:0] res,
    input  logic         half_mode,
    output logic         neg,
    output logic         zero
);
    localparam int H = W / 2;

    // Pick the sign bit by width and test the active bits for zero.
    always_comb begin
        neg  = half_mode ? res[H-1] : res[W-1];
        zero = half_mode ? (res[H-1:0] == '0) : (res == '0);
    end
endmodule

// File: rtl/alu16_core.sv
// Two-operand ALU top: masks the operands to the active width, selects
// among binary, decimal and logical results, derives the status update
// rule per operation, and registers everything for one cycle of latency.
// Assumes flags_in holds the current status with the carry in bit 0.
module alu16_core
    import alu16_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] src_val,
    input  logic [W-1:0] dst_val,
    input  logic         byte_op,
    input  logic [3:0]   flags_in,
    output logic         out_valid,
    output logic [W-1:0] result,
    output logic         dst_we,
    output logic [3:0]   flags_out
);
    localparam int H = W / 2;

    logic [W-1:0] act_mask, s_m, d_m, as_b, as_sum, bcd_sum, res_pre, res_m;
    logic         as_cin, as_cout, as_ovf, bcd_cout;
    logic         nxt_we, upd_flags, v_sel, c_sel, c_from_z, n_w, z_w;
    alu_flags_t   in_f, nxt_f;
    alu_op_e      op;

    assign op   = alu_op_e'(op_sel);
    assign in_f = alu_flags_t'(flags_in);

    // Operand masking to the active width and add/subtract operand preparation.
    always_comb begin
        act_mask = byte_op ? {{(W-H){1'b0}}, {H{1'b1}}} : {W{1'b1}};
        s_m      = src_val & act_mask;
        d_m      = dst_val & act_mask;
        as_b     = (op == OP_SUB || op == OP_SUBC || op == OP_CMP) ? (~s_m & act_mask) : s_m;
        case (op)
            OP_ADD:              as_cin = 1'b0;
            OP_ADDC, OP_SUBC:    as_cin = in_f.c;
            default:             as_cin = 1'b1;
        endcase
    end

    alu16_addsub #(.W(W)) addsub_i (
        .a(d_m), .b(as_b), .cin(as_cin), .half_mode(byte_op),
        .sum(as_sum), .cout(as_cout), .ovf(as_ovf)
    );

    alu16_bcd #(.W(W)) bcd_i (
        .a(d_m), .b(s_m), .cin(in_f.c), .half_mode(byte_op),
        .sum(bcd_sum), .cout(bcd_cout)
    );

    // Per-operation result, write strobe and status-update rule.
    always_comb begin
        res_pre   = '0;
        nxt_we    = 1'b0;
        upd_flags = 1'b0;
        v_sel     = 1'b0;
        c_sel     = 1'b0;
        c_from_z  = 1'b0;
        case (op)
            OP_MOVE: begin res_pre = s_m; nxt_we = 1'b1; end
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBC: begin
                res_pre = as_sum; nxt_we = 1'b1; upd_flags = 1'b1;
                v_sel = as_ovf; c_sel = as_cout;
            end
            OP_CMP: begin
                res_pre = as_sum; upd_flags = 1'b1;
                v_sel = as_ovf; c_sel = as_cout;
            end
            OP_DADD: begin
                res_pre = bcd_sum; nxt_we = 1'b1; upd_flags = 1'b1; c_sel = bcd_cout;
            end
            OP_BTST: begin res_pre = s_m & d_m; upd_flags = 1'b1; c_from_z = 1'b1; end
            OP_BCLR: begin res_pre = ~s_m & d_m; nxt_we = 1'b1; end
            OP_BSET: begin res_pre = s_m | d_m; nxt_we = 1'b1; end
            OP_XOR: begin
                res_pre = s_m ^ d_m; nxt_we = 1'b1; upd_flags = 1'b1; c_from_z = 1'b1;
                v_sel = byte_op ? (s_m[H-1] & d_m[H-1]) : (s_m[W-1] & d_m[W-1]);
            end
            OP_AND: begin
                res_pre = s_m & d_m; nxt_we = 1'b1; upd_flags = 1'b1; c_from_z = 1'b1;
            end
            default: ;
        endcase
    end

    assign res_m = res_pre & act_mask;

    alu16_nzgen #(.W(W)) nz_i (
        .res(res_m), .half_mode(byte_op), .neg(n_w), .zero(z_w)
    );

    // Final status: new flags for updating operations, pass-through otherwise.
    always_comb begin
        if (upd_flags) begin
            nxt_f.v = v_sel;
            nxt_f.n = n_w;
            nxt_f.z = z_w;
            nxt_f.c = c_from_z ? ~z_w : c_sel;
        end else begin
            nxt_f = in_f;
        end
    end

    // Output registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            dst_we    <= 1'b0;
            result    <= '0;
            flags_out <= '0;
        end else begin
            out_valid <= in_valid;
            dst_we    <= in_valid & nxt_we;
            if (in_valid) begin
                result    <= res_m;
                flags_out <= nxt_f;
            end
        end
    end
endmodule

// File: rtl/alu16_chk.sv
// Property checker for alu16_core, attached by bind below.
// Assumes the top's default width of 16 bits.
module alu16_chk
    import alu16_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [3:0]  op_sel,
    input logic [15:0] src_val,
    input logic [15:0] dst_val,
    input logic        byte_op,
    input logic [3:0]  flags_in,
    input logic        out_valid,
    input logic [15:0] result,
    input logic        dst_we,
    input logic [3:0]  flags_out
);
    logic nz_op;
    assign nz_op = in_valid && (op_sel inside {4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11});

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !dst_we && result == 16'h0 && flags_out == 4'h0));

    assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (out_valid == $past(in_valid)));

    assert_idle_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dst_we);

    assert_byte_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_op) |=> (result[15:8] == 8'h00));

    assert_neg_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        nz_op |=> (flags_out[2] == ($past(byte_op) ? result[7] : result[15])));

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd5) |=> !dst_we);

    assert_logic_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 4'd7 || op_sel == 4'd11)) |=> (!flags_out[3] && flags_out[0] == !flags_out[1]));

    assert_btst_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd7) |=> !dst_we);

    assert_xor_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel == 4'd10) |=> (flags_out[0] == !flags_out[1]));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_sel == 4'd0 || op_sel == 4'd8 || op_sel == 4'd9)) |=> (flags_out == $past(flags_in)));

    assert_unused_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_sel >= 4'd12) |=> (!dst_we && result == 16'h0 && flags_out == $past(flags_in)));
endmodule

bind alu16_core alu16_chk chk_i (.*);

// File: tb/alu16_core_tb.sv
`timescale 1ns/1ps
module alu16_core_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [3:0]  op_sel = 4'd0;
    logic [15:0] src_val = 16'h0;
    logic [15:0] dst_val = 16'h0;
    logic        byte_op = 1'b0;
    logic [3:0]  flags_in = 4'h0;
    logic        out_valid;
    logic [15:0] result;
    logic        dst_we;
    logic [3:0]  flags_out;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    alu16_core dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
        .src_val(src_val), .dst_val(dst_val), .byte_op(byte_op),
        .flags_in(flags_in), .out_valid(out_valid), .result(result),
        .dst_we(dst_we), .flags_out(flags_out)
    );

    // Expected {we, V, N, Z, C, result} from the requirement text.
    function automatic logic [20:0] model(input logic [3:0] op, input logic [15:0] s, input logic [15:0] d,
                                          input logic bm, input logic [3:0] fi);
        int w, m, sm, dm, r, b, cin, sum, sa, sb, sr, cy, t;
        logic we, upd, v, n, z, c, cz;
        w = bm ? 8 : 16;
        m = bm ? 32'hFF : 32'hFFFF;
        sm = int'(s) & m;
        dm = int'(d) & m;
        r = 0; we = 0; upd = 1; v = 0; c = 0; cz = 0;
        case (op)
            4'd0: begin r = sm; we = 1; upd = 0; end
            4'd1, 4'd2, 4'd3, 4'd4, 4'd5: begin
                b   = (op >= 4'd3) ? (~sm & m) : sm;
                cin = (op == 4'd1) ? 0 : ((op == 4'd2 || op == 4'd4) ? int'(fi[0]) : 1);
                sum = dm + b + cin;
                r   = sum & m;
                c   = ((sum >> w) & 1) != 0;
                sa = (dm >> (w-1)) & 1; sb = (b >> (w-1)) & 1; sr = (r >> (w-1)) & 1;
                v  = (sa == sb) && (sr != sa);
                we = (op != 4'd5);
            end
            4'd6: begin
                cy = int'(fi[0]);
                for (int k = 0; k < w/4; k++) begin
                    t = ((sm >> (4*k)) & 15) + ((dm >> (4*k)) & 15) + cy;
                    if (t > 9) begin t = t + 6; cy = 1; end else cy = 0;
                    r = r | ((t & 15) << (4*k));
                end
                c = (cy != 0); we = 1;
            end
            4'd7:  begin r = sm & dm; cz = 1; end
            4'd8:  begin r = ~sm & dm & m; we = 1; upd = 0; end
            4'd9:  begin r = sm | dm; we = 1; upd = 0; end
            4'd10: begin r = sm ^ dm; we = 1; cz = 1; v = (((sm & dm) >> (w-1)) & 1) != 0; end
            4'd11: begin r = sm & dm; we = 1; cz = 1; end
            default: begin r = 0; upd = 0; end
        endcase
        n = ((r >> (w-1)) & 1) != 0;
        z = (r == 0);
        if (cz) c = !z;
        if (!upd) return {we, fi, r[15:0]};
        return {we, v, n, z, c, r[15:0]};
    endfunction

    function automatic string tag_of(input logic [3:0] op, input logic bm);
        case (op)
            4'd0, 4'd8, 4'd9: return "R9";
            4'd1, 4'd2, 4'd3, 4'd4: return bm ? "R3/R4" : "R4";
            4'd5: return "R5";
            4'd6: return "R6";
            4'd7, 4'd11: return "R7";
            4'd10: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Drive one operation at a falling edge, check outputs at the next falling edge.
    task automatic run_op(input logic [3:0] op, input logic [15:0] s, input logic [15:0] d,
                          input logic bm, input logic [3:0] fi);
        logic [20:0] exp_v, got_v;
        in_valid = 1'b1; op_sel = op; src_val = s; dst_val = d; byte_op = bm; flags_in = fi;
        exp_v = model(op, s, d, bm, fi);
        @(negedge clk);
        got_v = {dst_we, flags_out, result};
        total++;
        if (!out_valid || got_v != exp_v) begin
            bad++;
            $display("FAIL %s op=%0d s=%h d=%h byte=%0d fi=%h: got v=%0d we=%0d fl=%h res=%h exp v=1 we=%0d fl=%h res=%h",
                     tag_of(op, bm), op, s, d, bm, fi, out_valid, got_v[20], got_v[19:16], got_v[15:0],
                     exp_v[20], exp_v[19:16], exp_v[15:0]);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        process::self().srandom(32'd1234);
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        total++;
        if (out_valid || dst_we || result != 16'h0 || flags_out != 4'h0) begin
            bad++;
            $display("FAIL R1 reset: got v=%0d we=%0d res=%h fl=%h exp all zero", out_valid, dst_we, result, flags_out);
        end
        rst_n = 1'b1;
        @(negedge clk);
        // R2: idle cycle gives no valid and no write
        total++;
        if (out_valid || dst_we) begin
            bad++;
            $display("FAIL R2 idle: got v=%0d we=%0d exp 0 0", out_valid, dst_we);
        end

        // Directed corners
        run_op(4'd1, 16'h0001, 16'hFFFF, 1'b0, 4'h0); // R4 carry out, zero
        run_op(4'd1, 16'h0001, 16'h7FFF, 1'b0, 4'h0); // R4 overflow
        run_op(4'd1, 16'hAB80, 16'hCD80, 1'b1, 4'h0); // R3 byte carry, garbage upper
        run_op(4'd2, 16'h0000, 16'hFFFF, 1'b0, 4'h1); // R4 carry in
        run_op(4'd3, 16'h1234, 16'h1234, 1'b0, 4'h0); // R4 equal subtract
        run_op(4'd4, 16'h0001, 16'h0001, 1'b0, 4'h0); // R4 borrow via C=0
        run_op(4'd5, 16'h0001, 16'h8000, 1'b0, 4'h0); // R5 compare overflow, no write
        run_op(4'd6, 16'h0001, 16'h0999, 1'b0, 4'h0); // R6 ripple
        run_op(4'd6, 16'h0000, 16'h9999, 1'b0, 4'h1); // R6 full carry out
        run_op(4'd6, 16'h5501, 16'h3399, 1'b1, 4'h0); // R6 byte
        run_op(4'd7, 16'h00F0, 16'h0F0F, 1'b0, 4'hF); // R7 zero, C=0
        run_op(4'd10, 16'h8001, 16'h8000, 1'b0, 4'h0); // R8 both negative
        run_op(4'd0, 16'hBEEF, 16'h0000, 1'b1, 4'hA); // R9 move byte, flags held
        run_op(4'd13, 16'hFFFF, 16'hFFFF, 1'b0, 4'h5); // R10 unused code

        // Constrained random mix
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] rs, rd;
            logic [3:0]  rop;
            rop = 4'($urandom_range(0, 15));
            rs  = 16'($urandom);
            rd  = 16'($urandom);
            if (rop == 4'd6 && ($urandom_range(0, 1) == 1)) begin
                for (int k = 0; k < 4; k++) begin
                    rs[4*k +: 4] = 4'($urandom_range(0, 9));
                    rd[4*k +: 4] = 4'($urandom_range(0, 9));
                end
            end
            run_op(rop, rs, rd, 1'($urandom_range(0, 1)), 4'($urandom));
        end

        in_valid = 1'b0;
        @(negedge clk);
        // R2: dropping in_valid clears valid and write next cycle
        total++;
        if (out_valid || dst_we) begin
            bad++;
            $display("FAIL R2 drop: got v=%0d we=%0d exp 0 0", out_valid, dst_we);
        end
        finish_run();
    end
endmodule